// File: doc/BRIEF.md
# Two-wire serial EEPROM slave

This block is the slave side of a two-wire serial memory of 4096 bytes, arranged as 128 pages of 32 bytes. It oversamples the bus clock and data lines with the system clock, finds Start and Stop conditions, and checks each control byte against a fixed type code and three strap inputs. When the byte matches, the block acknowledges by pulling the shared data line low. It never drives that line high.

A write transfer carries a two-byte word address and then any number of data bytes. The data bytes collect in a 32-byte page buffer. After the closing Stop, a self-timed cycle copies the buffer into the array. Reads return the byte at the internal address counter and then advance it. A random read is a write transfer that carries only the address, followed by a repeated Start and a read.

A write-protect input guards the top quarter of the array. A Start at any point abandons the transfer in progress. This lets a master recover a stuck bus.

Top module: `twi_eeprom_slave`

## Requirements
- R1: A falling data edge while the clock is high is a Start, and a rising data edge while the clock is high is a Stop. A Start at any point ends the current transfer, discards buffered write data without committing it, and waits for a control byte.
- R2: The data output only requests a low level (`sda_pull_o` = 1) or releases the line. It asserts only while the bus clock is low. After each byte the block accepts, it holds the line low for the ninth clock. After reset the line is released.
- R3: A control byte is 4'b1010, then strap bits 2..0, then the read/write bit (1 = read), sent MSB first. Any other value is not acknowledged, and the line stays released until the next Start.
- R4: The word address is two bytes, high byte first. Only the low 12 bits are used, so the upper 4 bits of the high byte are ignored.
- R5: Write data bytes go to successive offsets within the addressed 32-byte page. The low 5 address bits wrap from 31 to 0, and the upper address bits stay fixed.
- R6: The buffered page is committed only after a Stop that follows at least one data byte. The block is then busy for WRITE_CYCLES clocks and does not acknowledge any control byte during that time.
- R7: With `wp_i` high at the Stop, bytes aimed at 0xC00..0xFFF are left unchanged, while lower addresses are written. With `wp_i` low, every address is writable.
- R8: A read returns the byte at the address counter and then increments the counter, rolling over from 0xFFF to 0x000. It keeps sending bytes while the master acknowledges. After a master no-acknowledge it releases the line. A read with no new address continues from the current counter.
- R9: All bytes are transferred MSB first in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_pull_o | output | 1 | 1 pulls the open-drain data line low, 0 releases it |
| strap_i | input | 3 | Device address straps (unconnected straps read 0) |
| wp_i | input | 1 | Write protect for the top quarter of the array |

## Verification
The bench writes across the end of a page. A design that carries into the page bits would land the third and fourth bytes in the next page instead of at offsets 0 and 1. It writes at 0xFFF and reads two bytes in sequence; a counter that does not roll over would return the wrong second byte. It repeats each protected-region write with `wp_i` high, at 0xBFF and at 0xC05. This catches a protection boundary off by one page or a protection that is ignored. It also sends a repeated Start before the Stop of a write, and a control byte while the commit is still busy. These expose designs that commit aborted data or that acknowledge during the internal cycle.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CTRL,
    PH_ADDRH,
    PH_ADDRL,
    PH_WDATA,
    PH_RDATA
  } phase_t;
endpackage

// File: rtl/twi_line_sampler.sv
module twi_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_q, sda_q, scl_s;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sync[g] <= 1'b1;
          sda_sync[g] <= 1'b1;
        end else if (g == 0) begin
          scl_sync[g] <= scl_i;
          sda_sync[g] <= sda_i;
        end else begin
          scl_sync[g] <= scl_sync[(g == 0) ? 0 : g-1];
          sda_sync[g] <= sda_sync[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign scl_s = scl_sync[SYNC_STAGES-1];
  assign sda_s = sda_sync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twi_page_store.sv
module twi_page_store #(
  parameter int ADDR_W       = 12,
  parameter int PAGE_W       = 5,
  parameter int WRITE_CYCLES = 1000000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     buf_clr,
  input  logic                     buf_we,
  input  logic [PAGE_W-1:0]        buf_off,
  input  logic [7:0]               buf_din,
  input  logic [ADDR_W-PAGE_W-1:0] page_idx,
  input  logic                     commit,
  input  logic                     wp_i,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [7:0]               rd_q,
  output logic                     busy_o
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int PIW        = ADDR_W - PAGE_W;
  localparam int CNT_W      = $clog2(WRITE_CYCLES + 1);

  logic [7:0]            mem [DEPTH];
  logic [7:0]            buf_data [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] buf_vld;
  logic [PIW-1:0]        page_lat;
  logic                  wp_lat;
  logic [CNT_W-1:0]      tcnt;
  logic                  busy;
  logic [PAGE_W-1:0]     wr_off;
  logic                  in_copy, top_quarter, wr_en;

  assign wr_off      = tcnt[PAGE_W-1:0];
  assign in_copy     = busy && (tcnt < CNT_W'(PAGE_BYTES));
  assign top_quarter = (page_lat[PIW-1 -: 2] == 2'b11);
  assign wr_en       = in_copy && buf_vld[wr_off] && !(wp_lat && top_quarter);
  assign busy_o      = busy;

  always_ff @(posedge clk) begin
    if (buf_we) buf_data[buf_off] <= buf_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_vld <= '0;
    end else if (buf_clr) begin
      buf_vld <= '0;
    end else if (buf_we) begin
      buf_vld[buf_off] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      tcnt     <= '0;
      page_lat <= '0;
      wp_lat   <= 1'b0;
    end else if (!busy) begin
      if (commit) begin
        busy     <= 1'b1;
        tcnt     <= '0;
        page_lat <= page_idx;
        wp_lat   <= wp_i;
      end
    end else begin
      tcnt <= tcnt + 1'b1;
      if (tcnt == CNT_W'(WRITE_CYCLES - 1)) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[{page_lat, wr_off}] <= buf_data[wr_off];
    rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave #(
  parameter int ADDR_W       = 12,
  parameter int PAGE_W       = 5,
  parameter int WRITE_CYCLES = 1000000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);
  import twi_pkg::*;

  localparam int AHW = ADDR_W - 8;
  localparam int PIW = ADDR_W - PAGE_W;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy;

  phase_t             phase;
  logic               ack_slot, m_ack, pull, wr_pending;
  logic [3:0]         bitcnt;
  logic [7:0]         shreg, txsh;
  logic [ADDR_W-1:0]  addr;
  logic [AHW-1:0]     addr_hi;
  logic               buf_clr, buf_we, commit;
  logic [PAGE_W-1:0]  buf_off;
  logic [7:0]         buf_din, rd_q;
  logic               ctrl_hit;

  twi_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_page_store #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .buf_clr(buf_clr), .buf_we(buf_we),
    .buf_off(buf_off), .buf_din(buf_din),
    .page_idx(addr[ADDR_W-1 -: PIW]), .commit(commit), .wp_i(wp_i),
    .rd_addr(addr), .rd_q(rd_q), .busy_o(busy)
  );

  assign ctrl_hit   = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == strap_i) && !busy;
  assign sda_pull_o = pull;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      ack_slot   <= 1'b0;
      m_ack      <= 1'b0;
      pull       <= 1'b0;
      wr_pending <= 1'b0;
      bitcnt     <= '0;
      shreg      <= '0;
      txsh       <= '1;
      addr       <= '0;
      addr_hi    <= '0;
      buf_clr    <= 1'b0;
      buf_we     <= 1'b0;
      commit     <= 1'b0;
      buf_off    <= '0;
      buf_din    <= '0;
    end else begin
      buf_clr <= 1'b0;
      buf_we  <= 1'b0;
      commit  <= 1'b0;
      if (start_det) begin
        phase      <= PH_CTRL;
        ack_slot   <= 1'b0;
        bitcnt     <= '0;
        pull       <= 1'b0;
        wr_pending <= 1'b0;
      end else if (stop_det) begin
        if (phase == PH_WDATA && wr_pending) commit <= 1'b1;
        phase      <= PH_IDLE;
        ack_slot   <= 1'b0;
        bitcnt     <= '0;
        pull       <= 1'b0;
        wr_pending <= 1'b0;
      end else if (phase == PH_RDATA) begin
        if (scl_rise && ack_slot) m_ack <= ~sda_s;
        if (scl_fall) begin
          if (!ack_slot) begin
            if (bitcnt == 4'd8) begin
              pull     <= 1'b0;
              ack_slot <= 1'b1;
            end else begin
              pull   <= ~txsh[7];
              txsh   <= {txsh[6:0], 1'b1};
              bitcnt <= bitcnt + 1'b1;
            end
          end else if (m_ack) begin
            pull     <= ~rd_q[7];
            txsh     <= {rd_q[6:0], 1'b1};
            bitcnt   <= 4'd1;
            ack_slot <= 1'b0;
            addr     <= addr + 1'b1;
          end else begin
            phase    <= PH_IDLE;
            pull     <= 1'b0;
            ack_slot <= 1'b0;
          end
        end
      end else if (phase != PH_IDLE) begin
        if (scl_rise && !ack_slot) begin
          shreg  <= {shreg[6:0], sda_s};
          bitcnt <= bitcnt + 1'b1;
        end
        if (scl_fall) begin
          if (ack_slot) begin
            pull     <= 1'b0;
            ack_slot <= 1'b0;
            bitcnt   <= '0;
          end else if (bitcnt == 4'd8) begin
            pull     <= 1'b1;
            ack_slot <= 1'b1;
            bitcnt   <= '0;
            case (phase)
              PH_CTRL: begin
                if (!ctrl_hit) begin
                  phase    <= PH_IDLE;
                  pull     <= 1'b0;
                  ack_slot <= 1'b0;
                end else if (shreg[0]) begin
                  phase <= PH_RDATA;
                  m_ack <= 1'b1;
                end else begin
                  phase <= PH_ADDRH;
                end
              end
              PH_ADDRH: begin
                addr_hi <= shreg[AHW-1:0];
                phase   <= PH_ADDRL;
              end
              PH_ADDRL: begin
                addr    <= {addr_hi, shreg};
                buf_clr <= 1'b1;
                phase   <= PH_WDATA;
              end
              default: begin
                buf_we              <= 1'b1;
                buf_off             <= addr[PAGE_W-1:0];
                buf_din             <= shreg;
                addr[PAGE_W-1:0]    <= addr[PAGE_W-1:0] + 1'b1;
                wr_pending          <= 1'b1;
              end
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/twi_eeprom_checker.sv
module twi_eeprom_checker #(
  parameter int WRITE_CYCLES = 1000000
) (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_pull_o,
  input logic start_det,
  input logic stop_det,
  input logic busy
);
  logic [31:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_len <= '0;
    else        busy_len <= busy ? busy_len + 1'b1 : '0;
  end

  // R2: the line is only pulled low while the bus clock is low
  a_r2_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_i);

  // R1: a Start always releases the line on the next cycle
  a_r1_start_release: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_pull_o);

  // R1: a Stop also leaves the line released
  a_r1_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull_o);

  // R6: the internal cycle only ever starts two cycles after a Stop
  a_r6_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det, 2));

  // R6: the internal cycle lasts exactly WRITE_CYCLES clocks
  a_r6_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == 32'(WRITE_CYCLES)));
endmodule

bind twi_eeprom_slave twi_eeprom_checker #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
  .start_det(start_det), .stop_det(stop_det), .busy(busy)
);

// File: tb/test_twi_eeprom_slave.sv
`timescale 1ns/1ps
module test_twi_eeprom_slave;
  localparam int WR = 2000;
  localparam int Q  = 16;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] CW = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] CR = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic pull;
  logic sda_bus;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_bus = sda_m & ~pull;

  twi_eeprom_slave #(.WRITE_CYCLES(WR)) i_twi_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(pull), .strap_i(STRAP), .wp_i(wp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq();
      scl_m = 1'b1; wq(2);
      scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    acked = ~sda_bus;
    wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq();
      scl_m = 1'b1; wq();
      b[i] = sda_bus;
      wq();
      scl_m = 1'b0;
    end
    wq();
    sda_m = ~give_ack; wq();
    scl_m = 1'b1; wq(2);
    scl_m = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  task automatic wr_page(input logic [15:0] a, input logic [31:0] d, input int n,
                         output logic ok);
    logic ak;
    ok = 1'b1;
    bus_start();
    send_byte(CW, ak); ok &= ak;
    send_byte(a[15:8], ak); ok &= ak;
    send_byte(a[7:0], ak); ok &= ak;
    for (int i = 0; i < n; i++) begin
      send_byte(d[8*i +: 8], ak); ok &= ak;
    end
    bus_stop();
  endtask

  task automatic rd_seq(input logic [15:0] a, input int n, output logic [31:0] q);
    logic ak;
    logic [7:0] b;
    q = '0;
    bus_start();
    send_byte(CW, ak);
    send_byte(a[15:8], ak);
    send_byte(a[7:0], ak);
    bus_start();
    send_byte(CR, ak);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n-1, b);
      q[8*i +: 8] = b;
    end
    bus_stop();
  endtask

  task automatic wait_commit();
    repeat (WR + 200) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R2 reset releases line", {31'd0, pull}, 32'd0);
  endtask

  task automatic t_basic();
    logic ok;
    logic [31:0] q;
    logic ak;
    logic [7:0] b;
    wr_page(16'h0010, 32'h4C80_1201, 4, ok);
    chk("R2 R3 write transfer acknowledged", {31'd0, ok}, 32'd1);
    wait_commit();
    rd_seq(16'h0010, 4, q);
    chk("R8 R9 sequential read of page data", q, 32'h4C80_1201);
    rd_seq(16'h0010, 3, q);
    bus_start();
    send_byte(CR, ak);
    recv_byte(1'b0, b);
    chk("R8 release after master nack", {31'd0, pull}, 32'd0);
    bus_stop();
    chk("R8 current address read continues", {24'd0, b}, 32'h4C);
  endtask

  task automatic t_addr_hi();
    logic [31:0] q;
    rd_seq(16'hF010, 1, q);
    chk("R4 upper address bits ignored", q, 32'h01);
  endtask

  task automatic t_wrap();
    logic ok;
    logic [31:0] q;
    wr_page(16'h003E, 32'h4433_2211, 4, ok);
    wait_commit();
    rd_seq(16'h003E, 2, q);
    chk("R5 bytes before page end", q, 32'h2211);
    rd_seq(16'h0020, 2, q);
    chk("R5 bytes wrapped to page start", q, 32'h4433);
  endtask

  task automatic t_mismatch();
    logic ak;
    bus_start();
    send_byte({4'b1010, 3'b100, 1'b0}, ak);
    chk("R3 wrong strap not acknowledged", {31'd0, ak}, 32'd0);
    send_byte(8'h00, ak);
    chk("R3 line stays released after mismatch", {31'd0, ak}, 32'd0);
    bus_stop();
    bus_start();
    send_byte({4'b1011, STRAP, 1'b1}, ak);
    chk("R3 wrong type code not acknowledged", {31'd0, ak}, 32'd0);
    bus_stop();
  endtask

  task automatic t_busy();
    logic ok, ak;
    logic [31:0] q;
    wr_page(16'h0100, 32'h5A, 1, ok);
    bus_start();
    send_byte(CW, ak);
    chk("R6 no ack while busy", {31'd0, ak}, 32'd0);
    bus_stop();
    wait_commit();
    bus_start();
    send_byte(CW, ak);
    chk("R6 ack after internal cycle", {31'd0, ak}, 32'd1);
    bus_stop();
    rd_seq(16'h0100, 1, q);
    chk("R6 committed byte", q, 32'h5A);
  endtask

  task automatic t_wp();
    logic ok;
    logic [31:0] q;
    wp = 1'b0;
    wr_page(16'h0C05, 32'h11, 1, ok); wait_commit();
    wr_page(16'h0BFF, 32'h22, 1, ok); wait_commit();
    wp = 1'b1;
    wr_page(16'h0C05, 32'h99, 1, ok); wait_commit();
    chk("R7 protected write still acknowledged", {31'd0, ok}, 32'd1);
    wr_page(16'h0BFF, 32'h77, 1, ok); wait_commit();
    rd_seq(16'h0C05, 1, q);
    chk("R7 top quarter unchanged with wp high", q, 32'h11);
    rd_seq(16'h0BFF, 1, q);
    chk("R7 0xBFF writable with wp high", q, 32'h77);
    wp = 1'b0;
    wr_page(16'h0C05, 32'h99, 1, ok); wait_commit();
    rd_seq(16'h0C05, 1, q);
    chk("R7 top quarter writable with wp low", q, 32'h99);
  endtask

  task automatic t_abort();
    logic ok, ak;
    logic [31:0] q;
    wr_page(16'h0200, 32'h3C, 1, ok); wait_commit();
    bus_start();
    send_byte(CW, ak);
    send_byte(8'h02, ak);
    send_byte(8'h00, ak);
    send_byte(8'hC3, ak);
    bus_start();
    send_byte(CW, ak);
    chk("R1 repeated start starts no commit", {31'd0, ak}, 32'd1);
    bus_stop();
    wait_commit();
    rd_seq(16'h0200, 1, q);
    chk("R1 aborted data discarded", q, 32'h3C);
  endtask

  task automatic t_rollover();
    logic ok;
    logic [31:0] q;
    wr_page(16'h0FFF, 32'hE1, 1, ok); wait_commit();
    wr_page(16'h0000, 32'h1E, 1, ok); wait_commit();
    rd_seq(16'h0FFF, 2, q);
    chk("R8 read counter rolls over", q, 32'h1EE1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_basic();
    t_addr_hi();
    t_wrap();
    t_mismatch();
    t_busy();
    t_wp();
    t_abort();
    t_rollover();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule